// File: doc/BRIEF.md
# Banked Register File with Bit Addressing

This block is the lower 128-byte internal data store of a small 8-bit core. One byte array serves four views. A register port reaches R0..R7 of the bank chosen by two bank-select bits. A byte port accesses any location, either directly by address or indirectly through R0 or R1 of the current bank. A bit port sets, clears and reads single bits in a 16-byte region. A stack port pushes and pops through an 8-bit stack pointer.

All read paths are combinational from the array. All writes land on the rising clock edge through a single write path with fixed priority, so at most one byte changes per cycle. The bank select, the addresses and the strobes come from the core's decode and status logic. The upper 128 bytes and special-function decoding belong to other blocks.

Top module: `bank_bit_ram`

## Requirements
- R1: While rst_n is low and on the first cycle after it, sp reads 0x07 and every byte of the array reads 0x00.
- R2: The register port reaches byte bank*8+n for register n, where bank is {bank_sel[1], bank_sel[0]} with bank_sel[1] as the MSB; reg_rdata shows that byte and reg_we writes it.
- R3: A direct byte access (byte_ind=0) at byte_addr reaches the same storage as a register access, whatever bank_sel holds.
- R4: Bit address k (0..0x7F) names bit k[2:0] of byte 0x20+k[6:3]; bit_val shows that bit combinationally.
- R5: bit_set or bit_clr changes only the addressed bit, in one cycle, leaving the other seven bits of its byte unchanged; if both are high, set wins.
- R6: With byte_ind=1 the byte address is the content of R0 (ptr_sel=0) or R1 (ptr_sel=1) of the current bank, for both read and write.
- R7: An indirect address with bit 7 set reads as 0x00 and a write to it changes no byte.
- R8: A push increments sp and then writes stk_wdata at the new sp, so the first push after reset lands at 0x08; stk_rdata always shows the byte at sp (0x00 when sp bit 7 is set, and a push to such an address writes nothing).
- R9: A pop presents the byte at sp on stk_rdata in that cycle and then decrements sp.
- R10: push and pop high together raise stk_err in that cycle, and the stack part of the cycle is dropped: sp holds and the stack writes nothing.
- R11: When several writes are requested in one cycle, only one is performed, by priority push, byte write, register write, bit set/clear; the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Bank select, bit 1 is MSB |
| reg_idx | input | 3 | Register number n |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| byte_addr | input | 7 | Direct byte address |
| byte_ind | input | 1 | 1: indirect through R0/R1 |
| ptr_sel | input | 1 | Pointer register: 0 = R0, 1 = R1 |
| byte_we | input | 1 | Byte write strobe |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data |
| bit_addr | input | 7 | Bit address k |
| bit_set | input | 1 | Set addressed bit |
| bit_clr | input | 1 | Clear addressed bit |
| bit_val | output | 1 | Addressed bit value |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| stk_wdata | input | 8 | Data to push |
| stk_rdata | output | 8 | Byte at sp |
| sp | output | 8 | Stack pointer |
| stk_err | output | 1 | Push and pop in the same cycle |

## Verification
The bench builds the block with its default parameters: a 7-bit array address, a stack pointer reset of 0x07 and a bit region based at 0x20. Those defaults put the bit region boundaries (bit 0x00 and bit 0x7F), the first push at 0x08 and the bank rollover at 0x1F within a few directed cycles. A long random stack walk can drive sp past 0x7F into the region that reads as zero. Indirect pointers are drawn across the full 8-bit range, so out-of-range addresses appear about half the time.

// File: rtl/bank_bit_ram.sv
`timescale 1ns/100ps
module bank_bit_ram #(
  parameter int         AW       = 7,
  parameter logic [7:0] SP_INIT  = 8'h07,
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_sel,
  input  logic [2:0] reg_idx,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [6:0] byte_addr,
  input  logic       byte_ind,
  input  logic       ptr_sel,
  input  logic       byte_we,
  input  logic [7:0] byte_wdata,
  output logic [7:0] byte_rdata,
  input  logic [6:0] bit_addr,
  input  logic       bit_set,
  input  logic       bit_clr,
  output logic       bit_val,
  input  logic       push,
  input  logic       pop,
  input  logic [7:0] stk_wdata,
  output logic [7:0] stk_rdata,
  output logic [7:0] sp,
  output logic       stk_err
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    sp_q;
  logic [AW-1:0] reg_a, ptr_a, bit_a, wr_a;
  logic [7:0]    ptr, eff, bit_byte, bit_mask, sp_inc, wr_d;
  logic          eff_ok, do_push, do_pop, wr_en;

  assign reg_a     = AW'({bank_sel, reg_idx});
  assign ptr_a     = AW'({bank_sel, 2'b00, ptr_sel});
  assign reg_rdata = mem[reg_a];

  assign ptr        = mem[ptr_a];
  assign eff        = byte_ind ? ptr : {1'b0, byte_addr};
  assign eff_ok     = ~eff[7];
  assign byte_rdata = eff_ok ? mem[eff[AW-1:0]] : 8'h00;

  assign bit_a    = BIT_BASE[AW-1:0] + AW'(bit_addr[6:3]);
  assign bit_byte = mem[bit_a];
  assign bit_mask = 8'h01 << bit_addr[2:0];
  assign bit_val  = bit_byte[bit_addr[2:0]];

  assign sp        = sp_q;
  assign sp_inc    = sp_q + 8'd1;
  assign stk_rdata = sp_q[7] ? 8'h00 : mem[sp_q[AW-1:0]];
  assign stk_err   = push & pop;
  assign do_push   = push & ~pop;
  assign do_pop    = pop & ~push;

  always_comb begin
    wr_en = 1'b0;
    wr_a  = '0;
    wr_d  = 8'h00;
    if (do_push) begin
      wr_en = ~sp_inc[7];
      wr_a  = sp_inc[AW-1:0];
      wr_d  = stk_wdata;
    end else if (byte_we) begin
      wr_en = eff_ok;
      wr_a  = eff[AW-1:0];
      wr_d  = byte_wdata;
    end else if (reg_we) begin
      wr_en = 1'b1;
      wr_a  = reg_a;
      wr_d  = reg_wdata;
    end else if (bit_set | bit_clr) begin
      wr_en = 1'b1;
      wr_a  = bit_a;
      wr_d  = bit_set ? (bit_byte | bit_mask) : (bit_byte & ~bit_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= SP_INIT;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (do_push)     sp_q <= sp_inc;
      else if (do_pop) sp_q <= sp_q - 8'd1;
      if (wr_en) mem[wr_a] <= wr_d;
    end
  end
endmodule

// File: rtl/bank_bit_ram_chk.sv
`timescale 1ns/100ps
module bank_bit_ram_chk #(
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input logic       clk,
  input logic       rst_n,
  input logic       push,
  input logic       pop,
  input logic       byte_we,
  input logic       reg_we,
  input logic       bit_set,
  input logic       bit_clr,
  input logic [6:0] bit_addr,
  input logic       bit_val,
  input logic [7:0] eff,
  input logic [7:0] byte_rdata,
  input logic [7:0] stk_wdata,
  input logic [7:0] stk_rdata,
  input logic [7:0] sp,
  input logic       stk_err
);
  p_sp_reset_r1: assert property (@(posedge clk) !rst_n |=> sp == SP_INIT);

  p_push_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> sp == $past(sp) + 8'd1);

  p_push_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && sp < 8'h7F) |=> stk_rdata == $past(stk_wdata));

  p_pop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp == $past(sp) - 8'd1);

  p_conflict_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(sp));

  p_conflict_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |-> (push && pop));

  p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eff[7] |-> byte_rdata == 8'h00);

  p_bit_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_set && !push && !byte_we && !reg_we) |=>
      (bit_addr != $past(bit_addr)) || bit_val);

  p_bit_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_clr && !bit_set && !push && !byte_we && !reg_we) |=>
      (bit_addr != $past(bit_addr)) || !bit_val);
endmodule

bind bank_bit_ram bank_bit_ram_chk #(.SP_INIT(SP_INIT)) i_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .byte_we(byte_we),
  .reg_we(reg_we), .bit_set(bit_set), .bit_clr(bit_clr), .bit_addr(bit_addr),
  .bit_val(bit_val), .eff(eff), .byte_rdata(byte_rdata), .stk_wdata(stk_wdata),
  .stk_rdata(stk_rdata), .sp(sp), .stk_err(stk_err)
);

// File: tb/test_bank_bit_ram.sv
`timescale 1ns/100ps
module test_bank_bit_ram;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bank_sel = 0;
  logic [2:0] reg_idx = 0;
  logic reg_we = 0, byte_ind = 0, ptr_sel = 0, byte_we = 0;
  logic bit_set = 0, bit_clr = 0, push = 0, pop = 0;
  logic [7:0] reg_wdata = 0, byte_wdata = 0, stk_wdata = 0;
  logic [6:0] byte_addr = 0, bit_addr = 0;
  logic [7:0] reg_rdata, byte_rdata, stk_rdata, sp;
  logic bit_val, stk_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m [128];
  logic [7:0] sp_m;

  always #2.5 clk = ~clk;

  bank_bit_ram i_bank_bit_ram (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] f_eff();
    return byte_ind ? m[{bank_sel, 2'b00, ptr_sel}] : {1'b0, byte_addr};
  endfunction

  function automatic logic [7:0] f_byte();
    logic [7:0] e = f_eff();
    return e[7] ? 8'h00 : m[e[6:0]];
  endfunction

  function automatic logic f_bit();
    return m[7'h20 + 7'(bit_addr[6:3])][bit_addr[2:0]];
  endfunction

  task automatic check_outputs();
    chk("R2 reg_rdata", reg_rdata, m[{bank_sel, reg_idx}]);
    chk("R3/R6/R7 byte_rdata", byte_rdata, f_byte());
    chk("R4 bit_val", {7'd0, bit_val}, {7'd0, f_bit()});
    chk("R8 stk_rdata", stk_rdata, sp_m[7] ? 8'h00 : m[sp_m[6:0]]);
    chk("R8/R9 sp", sp, sp_m);
    chk("R10 stk_err", {7'd0, stk_err}, {7'd0, push & pop});
  endtask

  task automatic step();
    logic [7:0] e, nsp, bb;
    logic [6:0] ba;
    #1;
    check_outputs();
    e = f_eff();
    nsp = sp_m + 8'd1;
    ba = 7'h20 + 7'(bit_addr[6:3]);
    bb = m[ba];
    @(posedge clk);
    if (push && !pop) begin
      if (!nsp[7]) m[nsp[6:0]] = stk_wdata;
    end else if (byte_we) begin
      if (!e[7]) m[e[6:0]] = byte_wdata;
    end else if (reg_we) m[{bank_sel, reg_idx}] = reg_wdata;
    else if (bit_set) m[ba] = bb | (8'h01 << bit_addr[2:0]);
    else if (bit_clr) m[ba] = bb & ~(8'h01 << bit_addr[2:0]);
    if (push && !pop) sp_m = nsp;
    else if (pop && !push) sp_m = sp_m - 8'd1;
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 0; byte_we = 0; bit_set = 0; bit_clr = 0; push = 0; pop = 0; byte_ind = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    sp_m = 8'h07;
    repeat (3) @(negedge clk);
    // R1: reset state observed through the direct byte port
    for (int a = 0; a < 128; a += 9) begin
      byte_addr = 7'(a);
      #1 chk("R1 reset byte", byte_rdata, 8'h00);
    end
    chk("R1 reset sp", sp, 8'h07);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: R3 of bank 2 is byte 0x13
    bank_sel = 2'b10; reg_idx = 3; reg_wdata = 8'hA5; reg_we = 1; step(); idle();
    bank_sel = 2'b01; byte_addr = 7'h13; #1 chk("R3 direct reads bank2 R3", byte_rdata, 8'hA5);
    step();
    // R8: first push lands at 0x08
    push = 1; stk_wdata = 8'h3C; step(); idle();
    byte_addr = 7'h08; #1 chk("R8 first push at 08", byte_rdata, 8'h3C);
    chk("R8 sp after push", sp, 8'h08);
    step();
    // R10: push and pop together
    push = 1; pop = 1; stk_wdata = 8'hEE; step(); idle();
    #1 chk("R10 sp held", sp, 8'h08);
    byte_addr = 7'h09; #1 chk("R10 no write", byte_rdata, 8'h00);
    step();
    // R9: pop shows top then decrements
    pop = 1; #1 chk("R9 pop data", stk_rdata, 8'h3C); step(); idle();
    #1 chk("R9 sp after pop", sp, 8'h07);
    // R5: bit 0x7F is bit 7 of byte 0x2F; set and clear together -> set
    byte_addr = 7'h2F; byte_wdata = 8'h15; byte_we = 1; step(); idle();
    bit_addr = 7'h7F; bit_set = 1; bit_clr = 1; step(); idle();
    byte_addr = 7'h2F; #1 chk("R5 set wins, others kept", byte_rdata, 8'h95);
    bit_addr = 7'h00; bit_set = 1; step(); idle();
    byte_addr = 7'h20; #1 chk("R4 bit 0 in byte 20", byte_rdata, 8'h01);
    // R6/R7: R1 of bank 1 (byte 0x09) as pointer
    bank_sel = 2'b01; reg_idx = 1; reg_wdata = 8'h40; reg_we = 1; step(); idle();
    byte_ind = 1; ptr_sel = 1; byte_wdata = 8'h77; byte_we = 1; step(); idle();
    byte_addr = 7'h40; #1 chk("R6 indirect write", byte_rdata, 8'h77);
    reg_wdata = 8'hC0; reg_we = 1; step(); idle();
    byte_ind = 1; ptr_sel = 1; byte_we = 1; byte_wdata = 8'h55; step(); idle();
    byte_addr = 7'h40; #1 chk("R7 oor write ignored", byte_rdata, 8'h77);
    // R11: push, byte and reg write together -> only push
    byte_addr = 7'h50; byte_wdata = 8'h11; byte_we = 1; reg_we = 1; reg_idx = 2;
    reg_wdata = 8'h22; push = 1; stk_wdata = 8'h33; step(); idle();
    byte_addr = 7'h50; #1 chk("R11 byte dropped", byte_rdata, 8'h00);
    chk("R11 reg dropped", reg_rdata, 8'h00);
    step();

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      idle();
      bank_sel = 2'($urandom); reg_idx = 3'($urandom);
      byte_addr = 7'($urandom); byte_ind = 1'($urandom);
      ptr_sel = 1'($urandom); bit_addr = 7'($urandom);
      reg_wdata = 8'($urandom); byte_wdata = 8'($urandom); stk_wdata = 8'($urandom);
      if (r < 15) reg_we = 1;
      else if (r < 30) byte_we = 1;
      else if (r < 45) bit_set = 1;
      else if (r < 58) bit_clr = 1;
      else if (r < 72) push = 1;
      else if (r < 84) pop = 1;
      else if (r < 88) begin push = 1; pop = 1; end
      else if (r < 94) begin reg_we = 1; byte_we = 1; bit_set = 1; end
      step();
    end
    idle();
    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule